// File: doc/BRIEF.md
# Dual-Modulus Feedback Divider Controller

This block is the digital side of a frequency synthesizer's feedback divider. A single fast input clock passes through an optional divide-by-two step. It then feeds a behavioural 16/17 dual-modulus prescaler. Two down-counters steer that prescaler: a 4-bit swallow count and a 13-bit main count. Together they divide the input by N = 16*M + A. Once per complete division cycle the block emits a one-clock pulse for the phase detector. A test tap toggles on each of those pulses, so it runs at half the divided rate.

The 17-bit ratio word and the divide-by-two select may change at any time. The block samples them only when a division cycle ends, so a cycle in progress always finishes with the settings it started with. Some ratios cannot be built from a 16/17 prescaler: those with a zero main count, and those whose swallow count exceeds the main count. The block flags such a ratio and keeps the divided output low. When the main count is zero, the block sits idle and samples the ratio word on every clock. Once it holds a legal ratio, it starts counting on the next clock.

Top module: `dmd_divider_ctrl`

## Requirements
- R1: The swallow count A is `ratio[3:0]` and the main count M is `ratio[16:4]`. With `half_en` low, consecutive `div_pulse` assertions are exactly 16*M + A clock cycles apart, which equals the ratio word read as an unsigned number.
- R2: With `half_en` high, consecutive `div_pulse` assertions are 2*(16*M + A) clock cycles apart.
- R3: Within each division cycle, `mod_ctl` is high for the first A prescaler periods and low for the rest. Its high time is 17*A clock cycles when `half_en` is low and 34*A clock cycles when it is high.
- R4: `div_pulse` is never high for two consecutive cycles.
- R5: `test_tap` changes value exactly in the cycles where `div_pulse` is high, and at no other time.
- R6: A ratio with M = 0 or M < A drives `bad_ratio` high, and while such a ratio is active `div_pulse` stays low.
- R7: `ratio` and `half_en` are sampled only at the end of a division cycle. A change made partway through a cycle leaves that cycle's length unchanged, and the new settings govern the following cycle.
- R8: During reset, `div_pulse`, `test_tap` and `mod_ctl` are low and `bad_ratio` is high. After reset is released, a legal ratio applied during reset is loaded on the first clock, so the first pulse is observed N+1 cycles after release.
- R9: After an illegal ratio is replaced by a legal one, `bad_ratio` clears and pulses resume with the new ratio's period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock to be divided |
| rst_n | input | 1 | Active-low synchronous reset |
| ratio | input | 17 | Division ratio: main count in bits 16:4, swallow count in bits 3:0 |
| half_en | input | 1 | Enables the divide-by-two step ahead of the prescaler |
| mod_ctl | output | 1 | Modulus control: high selects divide-by-17 |
| div_pulse | output | 1 | One-cycle pulse at the end of each division cycle |
| test_tap | output | 1 | Divided output halved again, for test observation |
| bad_ratio | output | 1 | Active ratio cannot be built from the 16/17 prescaler |

## Verification
The ratio patterns are chosen to separate distinct faults:
- Zero swallow count (pure divide-by-16 periods) and swallow count of one.
- Swallow count equal to the main count, the edge of legality.
- A large main count with a small swallow count, so main-count errors cannot hide behind swallow errors.
- Each pattern under both settings of the divide-by-two step.

Measuring the pulse spacing and the modulus-control high time in the same cycle separates a wrong total from a wrong split between /17 and /16 periods. A mid-cycle change of both ratio and step setting shows whether sampling happens only at the cycle boundary. Two kinds of illegal ratio, each followed by recovery, exercise the flag and the output hold.

// File: rtl/dmd_pkg.sv
package dmd_pkg;

  localparam int unsigned DMD_RATIO_W = 17;
  localparam int unsigned DMD_SWALLOW_W = 4;

  // Low-order swallow field of a ratio word.
  function automatic int unsigned f_swallow(input logic [31:0] r, input int unsigned aw);
    return r & ((32'd1 << aw) - 32'd1);
  endfunction

  // High-order main-count field of a ratio word.
  function automatic int unsigned f_main(input logic [31:0] r, input int unsigned aw);
    return r >> aw;
  endfunction

  // A ratio is buildable only if the main count is non-zero and covers the swallow count.
  function automatic logic f_ratio_ok(input logic [31:0] r, input int unsigned aw);
    int unsigned m;
    int unsigned a;
    m = f_main(r, aw);
    a = f_swallow(r, aw);
    return (m != 0) && (m >= a);
  endfunction

endpackage

// File: rtl/dmd_half_stage.sv
module dmd_half_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic sel,
  output logic step
);
  logic tgl_q;

  always_ff @(posedge clk) begin
    if (!rst_n || hold) tgl_q <= 1'b0;
    else if (sel)       tgl_q <= ~tgl_q;
    else                tgl_q <= 1'b0;
  end

  assign step = sel ? tgl_q : 1'b1;

  // Sustained halving gives an enable that alternates every clock.
  AST_STEP_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !hold && $past(sel) && !$past(hold)) |-> (step != $past(step))); // R2
endmodule

// File: rtl/dmd_prescaler.sv
module dmd_prescaler #(
  parameter int unsigned SW_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic hold,
  input  logic mod_hi,
  output logic ptick
);
  localparam int unsigned LOW_MOD = 1 << SW_W;
  localparam int unsigned PC_W = SW_W + 1;

  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] last_val;

  assign last_val = mod_hi ? PC_W'(LOW_MOD) : PC_W'(LOW_MOD - 1);
  assign ptick = step && !hold && (pc_q == last_val);

  always_ff @(posedge clk) begin
    if (!rst_n || hold) pc_q <= '0;
    else if (step)      pc_q <= ptick ? '0 : pc_q + 1'b1;
  end

  // The phase counter never passes the high-modulus terminal value.
  AST_PC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    pc_q <= PC_W'(LOW_MOD)); // R3
endmodule

// File: rtl/dmd_counters.sv
module dmd_counters #(
  parameter int unsigned SW_W = 4,
  parameter int unsigned MN_W = 13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ptick,
  input  logic            load,
  input  logic [SW_W-1:0] a_in,
  input  logic [MN_W-1:0] m_in,
  output logic            mod_hi,
  output logic            last_tick,
  output logic            idle
);
  logic [SW_W-1:0] acnt_q;
  logic [MN_W-1:0] mcnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acnt_q <= '0;
      mcnt_q <= '0;
    end else if (load) begin
      acnt_q <= a_in;
      mcnt_q <= m_in;
    end else if (ptick) begin
      mcnt_q <= mcnt_q - 1'b1;
      if (acnt_q != '0) acnt_q <= acnt_q - 1'b1;
    end
  end

  assign mod_hi    = (acnt_q != '0);
  assign last_tick = ptick && (mcnt_q == MN_W'(1));
  assign idle      = (mcnt_q == '0);

  // The modulus only moves on a prescaler period boundary or a reload.
  AST_MOD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ptick && !load) |=> $stable(mod_hi)); // R3
endmodule

// File: rtl/dmd_divider_ctrl.sv
module dmd_divider_ctrl #(
  parameter int unsigned RATIO_W = dmd_pkg::DMD_RATIO_W,
  parameter int unsigned SW_W    = dmd_pkg::DMD_SWALLOW_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [RATIO_W-1:0] ratio,
  input  logic               half_en,
  output logic               mod_ctl,
  output logic               div_pulse,
  output logic               test_tap,
  output logic               bad_ratio
);
  import dmd_pkg::*;

  localparam int unsigned MN_W = RATIO_W - SW_W;

  logic [RATIO_W-1:0] ratio_q;
  logic               half_q;
  logic               step;
  logic               ptick;
  logic               mod_hi;
  logic               last_tick;
  logic               idle;
  logic               load;
  logic               cur_ok;
  logic               pulse_q;
  logic               tap_q;
  logic [SW_W-1:0]    a_next;
  logic [MN_W-1:0]    m_next;

  assign load   = last_tick | idle;
  assign cur_ok = f_ratio_ok(32'(ratio_q), SW_W);
  assign a_next = SW_W'(f_swallow(32'(ratio), SW_W));
  assign m_next = MN_W'(f_main(32'(ratio), SW_W));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ratio_q <= '0;
      half_q  <= 1'b0;
      pulse_q <= 1'b0;
      tap_q   <= 1'b0;
    end else begin
      pulse_q <= last_tick && cur_ok;
      if (last_tick && cur_ok) tap_q <= ~tap_q;
      if (load) begin
        ratio_q <= ratio;
        half_q  <= half_en;
      end
    end
  end

  dmd_half_stage u_half (
    .clk   (clk),
    .rst_n (rst_n),
    .hold  (idle),
    .sel   (half_q),
    .step  (step)
  );

  dmd_prescaler #(.SW_W(SW_W)) u_presc (
    .clk    (clk),
    .rst_n  (rst_n),
    .step   (step),
    .hold   (idle),
    .mod_hi (mod_hi),
    .ptick  (ptick)
  );

  dmd_counters #(.SW_W(SW_W), .MN_W(MN_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .ptick     (ptick),
    .load      (load),
    .a_in      (a_next),
    .m_in      (m_next),
    .mod_hi    (mod_hi),
    .last_tick (last_tick),
    .idle      (idle)
  );

  assign mod_ctl   = mod_hi;
  assign div_pulse = pulse_q;
  assign test_tap  = tap_q;
  assign bad_ratio = !cur_ok;

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |=> !div_pulse); // R4
  AST_TAP_FOLLOWS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |-> (test_tap != $past(test_tap))); // R5
  AST_TAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !div_pulse |-> $stable(test_tap)); // R5
  AST_NO_PULSE_WHEN_BAD: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |-> !$past(bad_ratio)); // R6
endmodule

// File: tb/dmd_divider_ctrl_tb.sv
module dmd_divider_ctrl_tb_top;
  logic        clk;
  logic        rst_n;
  logic [16:0] ratio;
  logic        half_en;
  logic        mod_ctl;
  logic        div_pulse;
  logic        test_tap;
  logic        bad_ratio;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 0;

  localparam int NV = 8;
  localparam logic [16:0] V_RATIO [NV] = '{17'd16, 17'd17, 17'd83, 17'd255,
                                           17'd320, 17'd119, 17'd1609, 17'd50};
  localparam bit V_HALF [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1};
  localparam int V_PER [NV] = '{16, 17, 83, 255, 640, 238, 1609, 100};

  dmd_divider_ctrl dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ratio     (ratio),
    .half_en   (half_en),
    .mod_ctl   (mod_ctl),
    .div_pulse (div_pulse),
    .test_tap  (test_tap),
    .bad_ratio (bad_ratio)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // Count samples until a pulse is seen (count includes the pulse sample).
  task automatic wait_pulse(input int limit, output int n, output bit found);
    n = 0;
    found = 0;
    while (n < limit && !found) begin
      @(negedge clk);
      n++;
      if (div_pulse) found = 1;
    end
  endtask

  // From the current sample, count samples up to the next pulse and the
  // modulus-control high samples in between.
  task automatic next_pulse(output int per, output int mcc, output bit wide, output bit tap_moved);
    logic t0;
    t0 = test_tap;
    per = 0;
    mcc = 0;
    wide = 0;
    do begin
      if (mod_ctl) mcc++;
      per++;
      @(negedge clk);
      if (per == 1 && div_pulse) wide = 1;
    end while (!div_pulse && per < 20000);
    tap_moved = (test_tap != t0);
  endtask

  initial begin
    int per;
    int mcc;
    int n;
    int pulses;
    bit wide;
    bit moved;
    bit found;

    rst_n = 1'b0;
    ratio = 17'd16;
    half_en = 1'b0;
    repeat (3) @(negedge clk);
    // R8: reset values
    check(div_pulse == 1'b0, "R8 pulse in reset", div_pulse, 0);
    check(test_tap == 1'b0, "R8 tap in reset", test_tap, 0);
    check(mod_ctl == 1'b0, "R8 mod_ctl in reset", mod_ctl, 0);
    check(bad_ratio == 1'b1, "R8 bad_ratio in reset", bad_ratio, 1);
    rst_n = 1'b1;
    wait_pulse(200, n, found);
    check(found && n == 17, "R8 first pulse after release", n, 17);

    // Main table: R1, R2, R3, R4, R5
    for (int i = 0; i < NV; i++) begin
      int a;
      int exp_mc;
      ratio = V_RATIO[i];
      half_en = V_HALF[i];
      a = int'(V_RATIO[i]) % 16;
      exp_mc = a * 17 * (V_HALF[i] ? 2 : 1);
      wait_pulse(5000, n, found);
      next_pulse(per, mcc, wide, moved);
      if (V_HALF[i]) check(per == V_PER[i], "R2 halved period", per, V_PER[i]);
      else           check(per == V_PER[i], "R1 period", per, V_PER[i]);
      check(mcc == exp_mc, "R3 modulus high time", mcc, exp_mc);
      check(!wide, "R4 pulse width", int'(wide), 0);
      check(moved, "R5 tap toggles", int'(moved), 1);
      check(!bad_ratio, "R6 legal ratio not flagged", bad_ratio, 0);
    end

    // R7: mid-cycle change of ratio and half_en
    ratio = 17'd48;
    half_en = 1'b0;
    wait_pulse(1000, n, found);
    next_pulse(per, mcc, wide, moved);
    check(per == 48, "R7 settle period", per, 48);
    repeat (3) @(negedge clk);
    ratio = 17'd33;
    half_en = 1'b1;
    next_pulse(per, mcc, wide, moved);
    check(per == 45, "R7 current cycle keeps old ratio", per + 3, 48);
    next_pulse(per, mcc, wide, moved);
    check(per == 66, "R7 new ratio next cycle", per, 66);

    // R6: swallow count above main count (M=2, A=5)
    ratio = 17'd37;
    half_en = 1'b0;
    repeat (120) @(negedge clk);
    check(bad_ratio == 1'b1, "R6 M<A flagged", bad_ratio, 1);
    pulses = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (div_pulse) pulses++;
    end
    check(pulses == 0, "R6 M<A no pulses", pulses, 0);

    // R6: zero main count
    ratio = 17'd5;
    repeat (60) @(negedge clk);
    check(bad_ratio == 1'b1, "R6 M=0 flagged", bad_ratio, 1);
    pulses = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (div_pulse) pulses++;
    end
    check(pulses == 0, "R6 M=0 no pulses", pulses, 0);

    // R9: recovery
    ratio = 17'd17;
    @(negedge clk);
    @(negedge clk);
    check(bad_ratio == 1'b0, "R9 flag clears", bad_ratio, 0);
    wait_pulse(200, n, found);
    check(found, "R9 pulses resume", int'(found), 1);
    next_pulse(per, mcc, wide, moved);
    check(per == 17, "R9 recovered period", per, 17);

    finish_run();
  end

  initial begin
    while (cyc < 150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
    finish_run();
  end
endmodule